// File: doc/BRIEF.md
# Configuration Request Descriptor Engine

This block turns software-programmed descriptor words into configuration read and write requests for a downstream configuration-access port. A host writes register words through a simple single-port register interface. The engine decodes the request type, finds the target bus, device/function and register offset, and forms the byte count and write data. It then presents one request at a time on the downstream port until that port signals completion.

There are two ways to launch a request. The external path takes a header word from its own register and three more words from a small push queue. The internal path packs a bridge-local request into a single register and always targets bus 0, device/function 0. Each path returns its result in its own read-data register. The external path also raises two sticky status bits that software clears by writing ones.

Top module: `cfg_tlp_engine`

Register word addresses on `regAddr`: 0 status (bit0 tx-idle, bit1 rx-busy, both write-1-to-clear; bit2 busy, read-only), 1 header word, 2 push (write-only, reads 0), 3 external control (bit0 fire), 4 external read data, 5 internal request, 6 internal write data, 7 internal control (bit0 fire), 8 internal read data. Unmapped addresses read 0.

## Requirements
- R1: Each write to the push register stores the word in a 3-entry queue at the current index, and the index then advances 0, 1, 2, 0 and wraps.
- R2: An accepted external fire uses the header register as word 0, queue entries 0, 1 and 2 as word 1, word 2 and write data, and returns the queue index to 0.
- R3: Word 0 bits [31:24] pick the request: 0x04 and 0x05 are reads, 0x44 and 0x45 are writes. Any other value makes no downstream request, but an external fire still sets both status bits.
- R4: Byte enables come from word 1 bits [3:0]. Word 2 gives bus in [31:24], device/function in [23:16] and dword offset in [11:2]. A read is always issued with length 4 at the dword address and with zero write data, and the returned data is stored unshifted.
- R5: A request whose bus equals the parameter ROOT_BUS (default 0x80) is issued to bus 0.
- R6: When `cfgPresent` is low at completion, the path's read-data register is loaded with 0xFFFFFFFF, for reads and for writes alike.
- R7: For a write, the length is the number of set enables, and enables of 0 make no request. Enables 0xF send the full word at the dword address. Any other pattern packs the enabled bytes, lowest first, into the low bytes, and adds the index of the lowest enabled byte to the address.
- R8: When an external request completes, status bits 0 and 1 are set. Writing 1 to a bit clears only that bit, and a set on the same cycle as the clear takes precedence.
- R9: The internal register supplies the address in bits [15:0], the enables in [19:16] and the write flag in bit 20. The request goes to bus 0, device/function 0, its result goes only to the internal read-data register, and it leaves the status bits unchanged.
- R10: Only one request is outstanding at a time. `cfgValid` and all request fields hold steady until `cfgDone`, status bit 2 reads 1 meanwhile, and fire writes during that time are ignored.
- R11: After reset there is no request, the status reads 0 and both read-data registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| cfgValid | output | 1 | Request outstanding |
| cfgWrite | output | 1 | 1 = write request |
| cfgBus | output | 8 | Target bus after remapping |
| cfgDevfn | output | 8 | Target device/function |
| cfgAddr | output | 12 | Byte address in configuration space |
| cfgLen | output | 3 | Byte count, 1 to 4 |
| cfgWdata | output | 32 | Write data, packed into the low bytes |
| cfgDone | input | 1 | Downstream completion pulse |
| cfgPresent | input | 1 | Target device responded, valid with `cfgDone` |
| cfgRdata | input | 32 | Read data, valid with `cfgDone` |

## Verification
A wrong queue index shows up on the very next launch: the descriptor words land in the wrong fields, so bus, address or write data are wrong on the cycle after the fire write. A packing or remap fault is visible at once on `cfgAddr`, `cfgLen`, `cfgWdata` or `cfgBus`. A stuck busy flag or a status fault shows in the status word and in `cfgValid` one cycle after `cfgDone`. A misrouted result shows in the wrong read-data register when it is read right after completion.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;

  localparam int QDEPTH = 3;
  localparam int QIW = $clog2(QDEPTH);

  localparam logic [3:0] A_STATUS   = 4'd0;
  localparam logic [3:0] A_HDR      = 4'd1;
  localparam logic [3:0] A_PUSH     = 4'd2;
  localparam logic [3:0] A_EXT_CTRL = 4'd3;
  localparam logic [3:0] A_EXT_RD   = 4'd4;
  localparam logic [3:0] A_INT_REQ  = 4'd5;
  localparam logic [3:0] A_INT_WD   = 4'd6;
  localparam logic [3:0] A_INT_CTRL = 4'd7;
  localparam logic [3:0] A_INT_RD   = 4'd8;

  localparam logic [7:0] FT_RD0 = 8'h04;
  localparam logic [7:0] FT_RD1 = 8'h05;
  localparam logic [7:0] FT_WR0 = 8'h44;
  localparam logic [7:0] FT_WR1 = 8'h45;

  typedef struct packed {
    logic        ok;
    logic        write;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [11:0] addr;
    logic [2:0]  len;
    logic [31:0] wdata;
  } cfgReq_t;

  typedef struct packed {
    logic launchExt;
    logic launchInt;
    logic rejectExt;
    logic finish;
    logic finishInt;
  } ctlStrobe_t;

  function automatic cfgReq_t decodeReq(input logic [31:0] d0, input logic [31:0] d1,
                                        input logic [31:0] d2, input logic [31:0] wd,
                                        input logic [7:0] rootBus);
    cfgReq_t r;
    logic [3:0] be;
    logic [11:0] base;
    logic [31:0] packedData;
    int idx;
    int first;
    r = '0;
    be = d1[3:0];
    base = {d2[11:2], 2'b00};
    r.bus = (d2[31:24] == rootBus) ? 8'h00 : d2[31:24];
    r.devfn = d2[23:16];
    packedData = '0;
    idx = 0;
    first = 0;
    for (int i = 0; i < 4; i++) begin
      if (be[i]) begin
        if (idx == 0) first = i;
        packedData[idx*8 +: 8] = wd[i*8 +: 8];
        idx++;
      end
    end
    case (d0[31:24])
      FT_RD0, FT_RD1: begin
        r.ok = 1'b1;
        r.addr = base;
        r.len = 3'd4;
      end
      FT_WR0, FT_WR1: begin
        r.ok = (be != 4'h0);
        r.write = 1'b1;
        if (be == 4'hF) begin
          r.addr = base;
          r.len = 3'd4;
          r.wdata = wd;
        end else begin
          r.addr = base + 12'(first);
          r.len = 3'(idx);
          r.wdata = packedData;
        end
      end
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfg_tlp_ctl.sv
module cfg_tlp_ctl
  import cfg_tlp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       extFireReq,
  input  logic       intFireReq,
  input  logic       extOk,
  input  logic       intOk,
  input  logic       cfgDone,
  output ctlStrobe_t strobe,
  output logic       busy
);

  logic curInt;

  always_comb begin
    strobe = '0;
    if (!busy) begin
      if (extFireReq) begin
        strobe.launchExt = extOk;
        strobe.rejectExt = !extOk;
      end else if (intFireReq) begin
        strobe.launchInt = intOk;
      end
    end else if (cfgDone) begin
      strobe.finish = 1'b1;
      strobe.finishInt = curInt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      curInt <= 1'b0;
    end else if (strobe.launchExt || strobe.launchInt) begin
      busy <= 1'b1;
      curInt <= strobe.launchInt;
    end else if (strobe.finish) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_tlp_dp.sv
module cfg_tlp_dp
  import cfg_tlp_pkg::*;
#(
  parameter logic [7:0] ROOT_BUS = 8'h80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  ctlStrobe_t  strobe,
  input  logic        busy,
  output logic        extFireReq,
  output logic        intFireReq,
  output logic        extOk,
  output logic        intOk,
  output logic        cfgWrite,
  output logic [7:0]  cfgBus,
  output logic [7:0]  cfgDevfn,
  output logic [11:0] cfgAddr,
  output logic [2:0]  cfgLen,
  output logic [31:0] cfgWdata,
  input  logic        cfgPresent,
  input  logic [31:0] cfgRdata
);

  logic [31:0] hdr;
  logic [31:0] queue [QDEPTH];
  logic [QIW-1:0] qIdx;
  logic [20:0] intReq;
  logic [31:0] intWdata, extRdata, intRdata;
  logic stTxIdle, stRxBusy;
  cfgReq_t extDec, intDec, selDec;
  logic pushWe, stWe, setSt, loadRes;
  logic [31:0] result;

  assign pushWe = regWe && (regAddr == A_PUSH);
  assign stWe = regWe && (regAddr == A_STATUS);
  assign extFireReq = regWe && (regAddr == A_EXT_CTRL) && regWdata[0];
  assign intFireReq = regWe && (regAddr == A_INT_CTRL) && regWdata[0];

  assign extDec = decodeReq(hdr, queue[0], queue[1], queue[2], ROOT_BUS);
  assign intDec = decodeReq(32'h0400_0001 | {1'b0, intReq[20], 30'd0},
                            32'h0040_1000 | {28'd0, intReq[19:16]},
                            {16'd0, intReq[15:0]}, intWdata, ROOT_BUS);
  assign extOk = extDec.ok;
  assign intOk = intDec.ok;
  assign selDec = strobe.launchInt ? intDec : extDec;

  assign setSt = strobe.rejectExt || (strobe.finish && !strobe.finishInt);
  assign result = cfgPresent ? cfgRdata : 32'hFFFF_FFFF;
  assign loadRes = strobe.finish && (!cfgPresent || !cfgWrite);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdr <= '0;
      for (int i = 0; i < QDEPTH; i++) queue[i] <= '0;
      qIdx <= '0;
      intReq <= '0;
      intWdata <= '0;
      extRdata <= '0;
      intRdata <= '0;
      stTxIdle <= 1'b0;
      stRxBusy <= 1'b0;
      cfgWrite <= 1'b0;
      cfgBus <= '0;
      cfgDevfn <= '0;
      cfgAddr <= '0;
      cfgLen <= '0;
      cfgWdata <= '0;
    end else begin
      if (pushWe) begin
        for (int i = 0; i < QDEPTH; i++)
          if (qIdx == QIW'(i)) queue[i] <= regWdata;
        qIdx <= (qIdx == QIW'(QDEPTH - 1)) ? '0 : qIdx + 1'b1;
      end
      if (strobe.launchExt || strobe.rejectExt) qIdx <= '0;
      if (regWe && regAddr == A_HDR) hdr <= regWdata;
      if (regWe && regAddr == A_INT_REQ) intReq <= regWdata[20:0];
      if (regWe && regAddr == A_INT_WD) intWdata <= regWdata;
      stTxIdle <= setSt || (stTxIdle && !(stWe && regWdata[0]));
      stRxBusy <= setSt || (stRxBusy && !(stWe && regWdata[1]));
      if (strobe.launchExt || strobe.launchInt) begin
        cfgWrite <= selDec.write;
        cfgBus <= selDec.bus;
        cfgDevfn <= selDec.devfn;
        cfgAddr <= selDec.addr;
        cfgLen <= selDec.len;
        cfgWdata <= selDec.wdata;
      end
      if (loadRes) begin
        if (strobe.finishInt) intRdata <= result;
        else extRdata <= result;
      end
    end
  end

  always_comb begin
    case (regAddr)
      A_STATUS:  regRdata = {29'd0, busy, stRxBusy, stTxIdle};
      A_HDR:     regRdata = hdr;
      A_EXT_RD:  regRdata = extRdata;
      A_INT_REQ: regRdata = {11'd0, intReq};
      A_INT_WD:  regRdata = intWdata;
      A_INT_RD:  regRdata = intRdata;
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/cfg_tlp_engine.sv
module cfg_tlp_engine
  import cfg_tlp_pkg::*;
#(
  parameter logic [7:0] ROOT_BUS = 8'h80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        cfgValid,
  output logic        cfgWrite,
  output logic [7:0]  cfgBus,
  output logic [7:0]  cfgDevfn,
  output logic [11:0] cfgAddr,
  output logic [2:0]  cfgLen,
  output logic [31:0] cfgWdata,
  input  logic        cfgDone,
  input  logic        cfgPresent,
  input  logic [31:0] cfgRdata
);

  ctlStrobe_t strobe;
  logic busy, extFireReq, intFireReq, extOk, intOk;

  assign cfgValid = busy;

  cfg_tlp_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .extFireReq(extFireReq), .intFireReq(intFireReq),
    .extOk(extOk), .intOk(intOk),
    .cfgDone(cfgDone), .strobe(strobe), .busy(busy)
  );

  cfg_tlp_dp #(.ROOT_BUS(ROOT_BUS)) u_dp (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .strobe(strobe), .busy(busy),
    .extFireReq(extFireReq), .intFireReq(intFireReq),
    .extOk(extOk), .intOk(intOk),
    .cfgWrite(cfgWrite), .cfgBus(cfgBus), .cfgDevfn(cfgDevfn),
    .cfgAddr(cfgAddr), .cfgLen(cfgLen), .cfgWdata(cfgWdata),
    .cfgPresent(cfgPresent), .cfgRdata(cfgRdata)
  );

endmodule

// File: rtl/cfg_tlp_engine_chk.sv
module cfg_tlp_engine_chk
  import cfg_tlp_pkg::*;
#(
  parameter logic [7:0] ROOT_BUS = 8'h80
) (
  input logic        clk,
  input logic        rstN,
  input logic        cfgValid,
  input logic        cfgDone,
  input logic        cfgWrite,
  input logic [7:0]  cfgBus,
  input logic [7:0]  cfgDevfn,
  input logic [11:0] cfgAddr,
  input logic [2:0]  cfgLen,
  input logic [31:0] cfgWdata,
  input ctlStrobe_t  strobe
);

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && !cfgDone |=> cfgValid && $stable({cfgWrite, cfgBus, cfgDevfn, cfgAddr, cfgLen, cfgWdata})); // R10
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && cfgDone |=> !cfgValid); // R10
  AST_READ_FULL: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && !cfgWrite |-> cfgLen == 3'd4 && cfgAddr[1:0] == 2'b00); // R4
  AST_WRITE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && cfgWrite |-> cfgLen != 3'd0 && cfgLen <= 3'd4); // R7
  AST_FULL_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && cfgWrite && cfgLen == 3'd4 |-> cfgAddr[1:0] == 2'b00); // R7
  AST_ROOT_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> (cfgBus != ROOT_BUS) || (ROOT_BUS == 8'h00)); // R5
  AST_REJECT_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid && strobe.rejectExt |=> !cfgValid); // R3

endmodule

bind cfg_tlp_engine cfg_tlp_engine_chk #(.ROOT_BUS(ROOT_BUS)) u_chk (
  .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgDone(cfgDone),
  .cfgWrite(cfgWrite), .cfgBus(cfgBus), .cfgDevfn(cfgDevfn), .cfgAddr(cfgAddr),
  .cfgLen(cfgLen), .cfgWdata(cfgWdata), .strobe(strobe)
);

// File: tb/sim_cfg_tlp_engine.sv
`timescale 1ns/1ps
module sim_cfg_tlp_engine;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic cfgValid, cfgWrite;
  logic [7:0] cfgBus, cfgDevfn;
  logic [11:0] cfgAddr;
  logic [2:0] cfgLen;
  logic [31:0] cfgWdata;
  logic cfgDone = 1'b0;
  logic cfgPresent = 1'b0;
  logic [31:0] cfgRdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfg_tlp_engine u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgBus(cfgBus),
    .cfgDevfn(cfgDevfn), .cfgAddr(cfgAddr), .cfgLen(cfgLen), .cfgWdata(cfgWdata),
    .cfgDone(cfgDone), .cfgPresent(cfgPresent), .cfgRdata(cfgRdata)
  );

  typedef struct packed {
    logic [31:0] h0;
    logic [31:0] d1;
    logic [31:0] d2;
    logic [31:0] wd;
    logic        pres;
    logic [31:0] rsp;
    logic        wr;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [11:0] addr;
    logic [2:0]  len;
    logic [31:0] ewd;
    logic [31:0] expRd;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{32'h04000001, 32'h0000000F, 32'h0108004C, 32'h00000000, 1'b1, 32'h12345678,
      1'b0, 8'h01, 8'h08, 12'h04C, 3'd4, 32'h00000000, 32'h12345678},
    '{32'h44000000, 32'h0000000C, 32'h00000040, 32'h11223344, 1'b0, 32'h00000000,
      1'b1, 8'h00, 8'h00, 12'h042, 3'd2, 32'h00001122, 32'hFFFFFFFF},
    '{32'h05000000, 32'h00000000, 32'h80100100, 32'hDEADBEEF, 1'b1, 32'h0BADBEEF,
      1'b0, 8'h00, 8'h10, 12'h100, 3'd4, 32'h00000000, 32'h0BADBEEF},
    '{32'h44000000, 32'h1234567F, 32'h02000010, 32'hAABBCCDD, 1'b1, 32'h55555555,
      1'b1, 8'h02, 8'h00, 12'h010, 3'd4, 32'hAABBCCDD, 32'h0BADBEEF},
    '{32'h45000000, 32'h00000004, 32'h03180020, 32'h11223344, 1'b1, 32'h00000000,
      1'b1, 8'h03, 8'h18, 12'h022, 3'd1, 32'h00000022, 32'h0BADBEEF},
    '{32'h45000000, 32'h00000005, 32'h7F000004, 32'hA1B2C3D4, 1'b1, 32'h00000000,
      1'b1, 8'h7F, 8'h00, 12'h004, 3'd2, 32'h0000B2D4, 32'h0BADBEEF},
    '{32'h04000000, 32'h0000000F, 32'h05000008, 32'h00000000, 1'b0, 32'h77777777,
      1'b0, 8'h05, 8'h00, 12'h008, 3'd4, 32'h00000000, 32'hFFFFFFFF},
    '{32'h05ABCDEF, 32'h00000003, 32'h80FF0FFC, 32'h00000000, 1'b1, 32'hCAFEF00D,
      1'b0, 8'h00, 8'hFF, 12'hFFC, 3'd4, 32'h00000000, 32'hCAFEF00D}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic respond(input logic pres, input logic [31:0] data);
    @(negedge clk);
    cfgDone = 1'b1; cfgPresent = pres; cfgRdata = data;
    @(negedge clk);
    cfgDone = 1'b0; cfgPresent = 1'b0; cfgRdata = '0;
  endtask

  task automatic checkReq(input string req, input logic w, input logic [7:0] b, input logic [7:0] df,
                          input logic [11:0] a, input logic [2:0] l, input logic [31:0] wdv);
    check(cfgValid == 1'b1, req, {63'd0, cfgValid}, 64'd1);
    check({cfgWrite, cfgBus, cfgDevfn, cfgAddr, cfgLen} == {w, b, df, a, l}, req,
          {32'd0, cfgWrite, cfgBus, cfgDevfn, cfgAddr, cfgLen}, {32'd0, w, b, df, a, l});
    check(cfgWdata == wdv, req, {32'd0, cfgWdata}, {32'd0, wdv});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(cfgValid == 1'b0, "R11 no request", {63'd0, cfgValid}, 64'd0);
    rd(4'd0, v); check(v == 32'd0, "R11 status", {32'd0, v}, 64'd0);
    rd(4'd4, v); check(v == 32'd0, "R11 ext rdata", {32'd0, v}, 64'd0);
    rd(4'd8, v); check(v == 32'd0, "R11 int rdata", {32'd0, v}, 64'd0);

    // R1 queue wraps after three pushes
    wr(4'd2, 32'h11111111); wr(4'd2, 32'h22222222); wr(4'd2, 32'h33333333);
    wr(4'd2, 32'h0000000F); wr(4'd2, 32'h02400080);
    wr(4'd1, 32'h44000000);
    wr(4'd3, 32'h1);
    checkReq("R1 wrap", 1'b1, 8'h02, 8'h40, 12'h080, 3'd4, 32'h33333333);
    respond(1'b1, 32'h0);

    // R2 index back to 0 after fire
    wr(4'd2, 32'h00000001); wr(4'd2, 32'h01000004); wr(4'd2, 32'h000000AB);
    wr(4'd3, 32'h1);
    checkReq("R2 index reset", 1'b1, 8'h01, 8'h00, 12'h004, 3'd1, 32'h000000AB);
    respond(1'b1, 32'h0);

    // Vector table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      wr(4'd1, VEC[i].h0);
      wr(4'd2, VEC[i].d1); wr(4'd2, VEC[i].d2); wr(4'd2, VEC[i].wd);
      wr(4'd3, 32'h1);
      checkReq($sformatf("R4/R5/R7 vector %0d", i), VEC[i].wr, VEC[i].bus, VEC[i].devfn,
               VEC[i].addr, VEC[i].len, VEC[i].ewd);
      respond(VEC[i].pres, VEC[i].rsp);
      check(cfgValid == 1'b0, "R10 released", {63'd0, cfgValid}, 64'd0);
      rd(4'd4, v);
      check(v == VEC[i].expRd, $sformatf("R6 rdata vector %0d", i), {32'd0, v}, {32'd0, VEC[i].expRd});
      rd(4'd0, v);
      check(v == 32'h3, "R8 status set", {32'd0, v}, 64'h3);
    end

    // R8 per-bit write-1-to-clear
    wr(4'd0, 32'h1);
    rd(4'd0, v); check(v == 32'h2, "R8 clear bit0 only", {32'd0, v}, 64'h2);
    wr(4'd0, 32'h2);
    rd(4'd0, v); check(v == 32'h0, "R8 clear bit1", {32'd0, v}, 64'h0);

    // R3 unknown type: no request, status still set
    wr(4'd1, 32'h24000000);
    wr(4'd2, 32'h0000000F); wr(4'd2, 32'h01000000); wr(4'd2, 32'h0);
    wr(4'd3, 32'h1);
    check(cfgValid == 1'b0, "R3 rejected type", {63'd0, cfgValid}, 64'd0);
    rd(4'd0, v); check(v == 32'h3, "R3 status on reject", {32'd0, v}, 64'h3);
    rd(4'd4, v); check(v == 32'hCAFEF00D, "R3 rdata untouched", {32'd0, v}, 64'hCAFEF00D);
    wr(4'd0, 32'h3);

    // R7 zero enables on a write: no request
    wr(4'd1, 32'h44000000);
    wr(4'd2, 32'h00000000); wr(4'd2, 32'h01000000); wr(4'd2, 32'h12345678);
    wr(4'd3, 32'h1);
    check(cfgValid == 1'b0, "R7 zero enables", {63'd0, cfgValid}, 64'd0);
    wr(4'd0, 32'h3);

    // R10 fire while busy is ignored
    wr(4'd1, 32'h04000000);
    wr(4'd2, 32'h0000000F); wr(4'd2, 32'h09000010); wr(4'd2, 32'h0);
    wr(4'd3, 32'h1);
    rd(4'd0, v); check(v == 32'h4, "R10 busy bit", {32'd0, v}, 64'h4);
    wr(4'd1, 32'h44000000);
    wr(4'd3, 32'h1);
    checkReq("R10 held while busy", 1'b0, 8'h09, 8'h00, 12'h010, 3'd4, 32'h0);
    // R8 set wins over a same-cycle clear
    @(negedge clk);
    cfgDone = 1'b1; cfgPresent = 1'b1; cfgRdata = 32'h00C0FFEE;
    regWe = 1'b1; regAddr = 4'd0; regWdata = 32'h3;
    @(negedge clk);
    cfgDone = 1'b0; cfgPresent = 1'b0; regWe = 1'b0;
    check(cfgValid == 1'b0, "R10 second fire ignored", {63'd0, cfgValid}, 64'd0);
    rd(4'd0, v); check(v == 32'h3, "R8 set beats clear", {32'd0, v}, 64'h3);
    wr(4'd0, 32'h3);

    // R9 internal write: bytes 1 and 2 of 0x55667788
    wr(4'd6, 32'h55667788);
    wr(4'd5, 32'h00160034);
    wr(4'd7, 32'h1);
    checkReq("R9 internal write", 1'b1, 8'h00, 8'h00, 12'h035, 3'd2, 32'h00006677);
    respond(1'b1, 32'h99999999);
    rd(4'd8, v); check(v == 32'h0, "R9 write leaves int rdata", {32'd0, v}, 64'h0);
    rd(4'd0, v); check(v == 32'h0, "R9 status untouched", {32'd0, v}, 64'h0);

    // R9 internal read
    wr(4'd5, 32'h000F0108);
    wr(4'd7, 32'h1);
    checkReq("R9 internal read", 1'b0, 8'h00, 8'h00, 12'h108, 3'd4, 32'h0);
    respond(1'b1, 32'h87654321);
    rd(4'd8, v); check(v == 32'h87654321, "R9 int rdata", {32'd0, v}, 64'h87654321);
    rd(4'd4, v); check(v == 32'h00C0FFEE, "R9 ext rdata kept", {32'd0, v}, 64'h00C0FFEE);
    rd(4'd0, v); check(v == 32'h0, "R9 status still clear", {32'd0, v}, 64'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule